// File: doc/BRIEF.md
# UART Receive Timeout Watchdog

This block tells a receive path that characters have been left waiting in its receive FIFO while the serial line has gone quiet. A down counter is loaded with a programmable number of bit-times. It counts down once per bit-time tick while the FIFO holds data and the line is idle. When it runs out and the watchdog is enabled, a sticky timeout flag is raised for the interrupt logic. Software or the interrupt handler drops the flag with a clear pulse. The flag also drops by itself once the FIFO has been drained.

The programmed value is an 8-bit count of eight-bit-time units with a fixed seven bit-times added, so the shortest timeout is 7 bit-times. A value that is changed mid-count is not applied at once. It is only taken when the counter next reloads, which happens at every frame end and for as long as the FIFO is empty. All pins are plain level or pulse control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure. A select input for the timeout source is present at the boundary, but only as a placeholder, and it does not change the timing.

Top module: `rx_tmo_watchdog`

## Requirements
- R1: The timeout length is tmo_units*8+7 bit-times. After a reload, the flag rises on the tick that completes that many qualifying ticks, and not before.
- R2: The counter moves only on a cycle with bit_tick high, fifo_nonempty high and line_idle high. Ticks while line_idle is low leave the remaining time unchanged.
- R3: frame_end high with fifo_nonempty high reloads the counter. This takes priority over a tick in the same cycle, and that cycle never raises the flag.
- R4: While fifo_nonempty is low, the counter holds the reload value taken from the current tmo_units, and tmo_flag goes low on the next edge.
- R5: The flag is raised only if wd_enable is high in the cycle where the count runs out. An expiry with wd_enable low is lost.
- R6: tmo_flag stays high until a cycle with tmo_clear high or fifo_nonempty low. If an expiry and tmo_clear fall in the same cycle, the flag is set.
- R7: After reset, tmo_flag is low and the counter holds 31 bit-times (default units value 3) until its first reload, whatever tmo_units is.
- R8: A change of tmo_units while counting does not alter the current countdown. It applies from the next reload.
- R9: Once expired, the counter stays at zero and does not raise the flag again until it has been reloaded.
- R10: src_sel has no effect on timing or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit-time |
| line_idle | input | 1 | Receive line is idle |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| frame_end | input | 1 | Pulse at the end of each received frame |
| wd_enable | input | 1 | Timeout enable |
| tmo_units | input | 8 | Programmed timeout in units of 8 bit-times (plus 7) |
| src_sel | input | 1 | Timeout source select, modelled only |
| tmo_clear | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky receive timeout flag |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This covers the flag rising on the expiring tick, the flag falling on a clear or on an empty FIFO, and a reload. The bench drives all inputs on the falling edge and samples tmo_flag on the next falling edge, after the one rising edge that registers the effect. This keeps each check on the cycle where the flag changes. For a countdown of N bit-times, the bench checks the flag low after N-1 ticks and high after the Nth tick, so that both an early and a late expiry are caught.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;
  // Units of the programmed value are 2**UNIT_SHIFT bit-times.
  localparam int unsigned UNIT_SHIFT    = 3;
  localparam int unsigned UNITS_W       = 8;
  localparam int unsigned DEFAULT_UNITS = 3;
  localparam int unsigned COUNT_W       = UNITS_W + UNIT_SHIFT;
endpackage

// File: rtl/tmo_reload_gen.sv
module tmo_reload_gen #(
  parameter int unsigned UNITS_W    = 8,
  parameter int unsigned UNIT_SHIFT = 3,
  localparam int unsigned COUNT_W   = UNITS_W + UNIT_SHIFT
) (
  input  logic [UNITS_W-1:0] units,
  output logic [COUNT_W-1:0] reload
);
  // units * 2**UNIT_SHIFT + (2**UNIT_SHIFT - 1): shift and fill with ones.
  generate
    if (UNIT_SHIFT == 0) begin : g_plain
      assign reload = units;
    end else begin : g_scaled
      assign reload = {units, {UNIT_SHIFT{1'b1}}};
    end
  endgenerate
endmodule

// File: rtl/tmo_down_counter.sv
module tmo_down_counter #(
  parameter int unsigned COUNT_W             = 11,
  parameter logic [COUNT_W-1:0] RESET_COUNT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [COUNT_W-1:0] reload,
  output logic               expire,
  output logic [COUNT_W-1:0] count
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic nonzero;
  assign nonzero = |count;
  // The step that takes the count from one to zero is the expiry event.
  assign expire  = !load && step && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= RESET_COUNT;
    end else if (load) begin
      count <= reload;
    end else if (step && nonzero) begin
      count <= count - ONE;
    end
  end
endmodule

// File: rtl/tmo_flag_reg.sv
module tmo_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic flag
);
  // Set has priority so an expiry coinciding with a clear is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clear) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_tmo_watchdog.sv
module rx_tmo_watchdog
  import rx_tmo_pkg::*;
#(
  parameter int unsigned UNITS_P   = UNITS_W,
  parameter int unsigned SHIFT_P   = UNIT_SHIFT,
  parameter int unsigned DEFAULT_P = DEFAULT_UNITS,
  localparam int unsigned CNT_W    = UNITS_P + SHIFT_P
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               line_idle,
  input  logic               fifo_nonempty,
  input  logic               frame_end,
  input  logic               wd_enable,
  input  logic [UNITS_P-1:0] tmo_units,
  input  logic               src_sel,
  input  logic               tmo_clear,
  output logic               tmo_flag
);
  localparam logic [UNITS_P-1:0] DEF_UNITS  = UNITS_P'(DEFAULT_P);
  localparam logic [CNT_W-1:0]   RESET_LOAD =
    CNT_W'((int'(DEF_UNITS) << SHIFT_P) + ((1 << SHIFT_P) - 1));

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count_q;
  logic             load;
  logic             step;
  logic             expire;
  logic             unused_src;

  // Source selection is carried at the boundary only.
  assign unused_src = src_sel;

  assign load = !fifo_nonempty || frame_end;
  assign step = bit_tick && line_idle && fifo_nonempty;

  tmo_reload_gen #(
    .UNITS_W   (UNITS_P),
    .UNIT_SHIFT(SHIFT_P)
  ) u_reload (
    .units (tmo_units),
    .reload(reload_val)
  );

  tmo_down_counter #(
    .COUNT_W    (CNT_W),
    .RESET_COUNT(RESET_LOAD)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .reload(reload_val),
    .expire(expire),
    .count (count_q)
  );

  tmo_flag_reg u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (expire && wd_enable),
    .clear(tmo_clear || !fifo_nonempty),
    .flag (tmo_flag)
  );
endmodule

// File: rtl/rx_tmo_watchdog_chk.sv
module rx_tmo_watchdog_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             line_idle,
  input logic             fifo_nonempty,
  input logic             frame_end,
  input logic             wd_enable,
  input logic             tmo_clear,
  input logic             tmo_flag,
  input logic [CNT_W-1:0] count_q
);
  // R5
  assert_rise_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(wd_enable));

  // R2
  assert_rise_needs_idle_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(bit_tick && line_idle && fifo_nonempty));

  // R3
  assert_frame_end_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !$rose(tmo_flag));

  // R4
  assert_empty_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |=> !tmo_flag);

  // R6
  assert_fall_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> $past(tmo_clear || !fifo_nonempty));

  // R9
  assert_zero_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && fifo_nonempty && !frame_end) |=> (count_q == '0));
endmodule

bind rx_tmo_watchdog rx_tmo_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .line_idle    (line_idle),
  .fifo_nonempty(fifo_nonempty),
  .frame_end    (frame_end),
  .wd_enable    (wd_enable),
  .tmo_clear    (tmo_clear),
  .tmo_flag     (tmo_flag),
  .count_q      (count_q)
);

// File: tb/rx_tmo_watchdog_bench.sv
module rx_tmo_watchdog_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       line_idle = 1'b1;
  logic       fifo_nonempty = 1'b0;
  logic       frame_end = 1'b0;
  logic       wd_enable = 1'b1;
  logic [7:0] tmo_units = 8'd0;
  logic       src_sel = 1'b0;
  logic       tmo_clear = 1'b0;
  logic       tmo_flag;

  int n_checks = 0;
  int n_errors = 0;

  always #5ns clk = ~clk;

  rx_tmo_watchdog u_rx_tmo_watchdog (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_idle(line_idle),
    .fifo_nonempty(fifo_nonempty), .frame_end(frame_end), .wd_enable(wd_enable),
    .tmo_units(tmo_units), .src_sel(src_sel), .tmo_clear(tmo_clear),
    .tmo_flag(tmo_flag)
  );

  // Row: tick idle fifo eof en clr units[7:0] expected_flag
  localparam int NV = 38;
  localparam logic [14:0] VEC [NV] = '{
    15'b0_1_1_0_1_0_00000000_0, // R2 no tick, no move
    15'b1_1_1_0_1_0_00000000_0, // R1 tick 1
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0, // R1 tick 6
    15'b1_1_1_0_1_0_00000000_1, // R1 tick 7 expires
    15'b1_1_1_0_1_0_00000000_1, // R6 sticky
    15'b0_1_1_0_1_1_00000000_0, // R6 clear pulse
    15'b1_1_1_0_1_0_00000000_0, // R9 no refire at zero
    15'b0_1_0_0_1_0_00000000_0, // R4 empty reloads 7
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0, // count at 2
    15'b1_1_1_1_1_0_00000000_0, // R3 frame end reloads over tick
    15'b1_0_1_0_1_0_00000000_0, // R2 line busy holds
    15'b1_0_1_0_1_0_00000000_0,
    15'b1_0_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0,
    15'b1_1_1_0_1_0_00000000_0, // R3 six after reload
    15'b1_1_1_0_1_0_00000000_1, // R3 seventh expires
    15'b0_1_0_0_1_0_00000000_0, // R4 empty drops flag
    15'b1_1_1_0_0_0_00000000_0, // R5 disabled countdown
    15'b1_1_1_0_0_0_00000000_0,
    15'b1_1_1_0_0_0_00000000_0,
    15'b1_1_1_0_0_0_00000000_0,
    15'b1_1_1_0_0_0_00000000_0,
    15'b1_1_1_0_0_0_00000000_0,
    15'b1_1_1_0_0_0_00000000_0, // R5 expiry lost
    15'b1_1_1_0_1_0_00000000_0, // R5 R9 enable later, no fire
    15'b0_1_0_0_1_0_00000000_0  // R4 flush
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: tmo_flag=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic t, input logic i, input logic f, input logic e,
                        input logic en, input logic c, input logic [7:0] u);
    bit_tick = t; line_idle = i; fifo_nonempty = f; frame_end = e;
    wd_enable = en; tmo_clear = c; tmo_units = u;
  endtask

  // n qualifying ticks, flag expected low throughout
  task automatic ticks_low(input int n, input logic [7:0] u, input string req);
    for (int k = 0; k < n; k++) begin
      set_in(1, 1, 1, 0, 1, 0, u);
      cyc();
      check(tmo_flag, 1'b0, req);
    end
  endtask

  task automatic flush(input logic [7:0] u);
    set_in(0, 1, 0, 0, 1, 0, u);
    cyc();
    check(tmo_flag, 1'b0, "R4 flush");
  endtask

  initial begin
    #1ms;
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R7: FIFO already holds data at reset release; units input 0 not yet applied
    set_in(0, 1, 1, 0, 1, 0, 8'd0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(tmo_flag, 1'b0, "R7 reset state");
    rst_n = 1'b1;
    ticks_low(30, 8'd0, "R7 default 31 not yet");
    set_in(1, 1, 1, 0, 1, 0, 8'd0);
    cyc();
    check(tmo_flag, 1'b1, "R7 default 31 expiry");
    flush(8'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      set_in(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11],
             VEC[v][10], VEC[v][9], VEC[v][8:1]);
      cyc();
      check(tmo_flag, VEC[v][0], $sformatf("R1-table row %0d", v));
    end

    // R1: largest value, 255*8+7 = 2047 bit-times
    flush(8'd255);
    ticks_low(2046, 8'd255, "R1 max early");
    set_in(1, 1, 1, 0, 1, 0, 8'd255);
    cyc();
    check(tmo_flag, 1'b1, "R1 max expiry");
    flush(8'd1);

    // R8: start 15-bit-time countdown, change units mid-count
    ticks_low(5, 8'd1, "R8 before change");
    ticks_low(9, 8'd0, "R8 after change");
    set_in(1, 1, 1, 0, 1, 0, 8'd0);
    cyc();
    check(tmo_flag, 1'b1, "R8 old length kept");
    flush(8'd0);

    // R6: expiry and clear in same cycle, set wins
    ticks_low(6, 8'd0, "R6 pre");
    set_in(1, 1, 1, 0, 1, 1, 8'd0);
    cyc();
    check(tmo_flag, 1'b1, "R6 set beats clear");
    flush(8'd0);

    // R10: select input changes nothing
    src_sel = 1'b1;
    ticks_low(6, 8'd0, "R10 early");
    set_in(1, 1, 1, 0, 1, 0, 8'd0);
    cyc();
    check(tmo_flag, 1'b1, "R10 same expiry");
    src_sel = 1'b0;
    flush(8'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule